// File: doc/BRIEF.md
# Outstanding Victim Command Throttle

This block sits beside the command issue path of a processor's system bus interface and decides, cycle by cycle, whether the next command of each class may go out. It keeps two counts of commands the system has not yet finished with. One count covers victim writebacks, both dirty and clean. The other covers every command that needs a system acknowledge. Each count has its own programmable limit, and a limit of zero switches that throttle off.

A requester presents one command per cycle with a 3-bit kind code. The block answers in the same cycle with `req_acc`. Only an accepted command is counted. A refused command is simply not issued, and the requester retries it later. The system cannot refuse a command once it has been issued, so a counted command stays counted until its done pulse arrives.

Two options tie reads that carry a victim to their victim. With pairing on, such a read is held back whenever the victim throttle is full, because the pair must go out together. With ack-inhibit on, such a read rides on its victim's acknowledge slot: it is not added to the acknowledge count, and the acknowledge limit does not block it.

Top module: `wig_issue_gate`

## Requirements
- R1: When `cfg_vic_lim` is nonzero and `vic_outstanding` >= `cfg_vic_lim`, `gnt_vic` and `vic_stall` reflect a full throttle: `gnt_vic` = 0, `vic_stall` = 1, and requests of kind 1 (dirty victim) or kind 2 (clean victim) get `req_acc` = 0.
- R2: When `cfg_vic_lim` = 0, the victim count never blocks a victim request, up to the counter capacity of 2^(VIC_LIM_W+1)-1 (15 by default).
- R3: A kind 3 request (read with victim) is refused while `cfg_pair_en` = 1 and the victim throttle is full. While `cfg_pair_en` = 0, the victim count does not affect it.
- R4: When `cfg_ack_lim` is nonzero and `ack_outstanding` >= `cfg_ack_lim`, the following hold: `ack_stall` = 1, `gnt_rd` = 0 and `gnt_vic` = 0, and `gnt_rdvic` = 0 unless `cfg_ack_inh` = 1. A value of 0 in `cfg_ack_lim` switches this limit off.
- R5: An accepted kind 3 request adds 1 to `ack_outstanding` when `cfg_ack_inh` = 0. When `cfg_ack_inh` = 1, it leaves `ack_outstanding` unchanged.
- R6: Kind 0 and kinds 5 to 7 need no response. They are always accepted and change neither count.
- R7: An accepted kind 1 or kind 2 request adds 1 to both counts on the next edge. An accepted kind 4 request (plain read) adds 1 to `ack_outstanding` only. A refused request changes nothing.
- R8: A `vic_done` pulse takes 1 from `vic_outstanding`, and an `ack_done` pulse takes 1 from `ack_outstanding`. An increment and a done pulse for the same count in the same cycle leave that count unchanged.
- R9: A done pulse on a count that is zero, with no increment to that count in the same cycle, leaves the count at 0 and sets `err_underflow`. The flag stays set until reset.
- R10: A limit changed while commands are outstanding does not alter either count. It only changes the grants for new requests.
- R11: After reset both counts are 0, all three grants are 1, and `err_underflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vic_lim | input | VIC_LIM_W | Victim limit, 0 = off |
| cfg_ack_lim | input | ACK_LIM_W | Acknowledge limit, 0 = off |
| cfg_pair_en | input | 1 | Read-with-victim follows its victim as a pair |
| cfg_ack_inh | input | 1 | Read-with-victim is not acknowledge-counted |
| req_vld | input | 1 | Command request this cycle |
| req_kind | input | 3 | 0 no-response, 1 dirty victim, 2 clean victim, 3 read with victim, 4 plain read, 5-7 no-response |
| vic_done | input | 1 | System finished one victim command |
| ack_done | input | 1 | System acknowledged one counted command |
| gnt_vic | output | 1 | Victim commands may issue |
| gnt_rdvic | output | 1 | Read-with-victim may issue |
| gnt_rd | output | 1 | Plain read may issue |
| req_acc | output | 1 | Current request accepted and counted |
| vic_stall | output | 1 | Victim throttle full |
| ack_stall | output | 1 | Acknowledge throttle full |
| vic_outstanding | output | VIC_LIM_W+1 | Victim commands in flight |
| ack_outstanding | output | ACK_LIM_W+1 | Acknowledge-counted commands in flight |
| err_underflow | output | 1 | Sticky: done pulse arrived with count at zero |

## Verification
An issue and a done pulse for the same count can fall in the same cycle. The bench provokes this by presenting an accepted victim request together with `vic_done` and `ack_done`, and it also combines an increment with a done pulse while the count is at zero. The scoreboard expects both counts to stay where they were, and it expects no new underflow. A second overlap happens when a limit is lowered below the current count: the bench expects the counts to be unchanged and the grants to drop on the next request.

// File: rtl/wig_pkg.sv
package wig_pkg;
   typedef enum logic [2:0] {
      K_NORSP     = 3'd0,
      K_VIC_DIRTY = 3'd1,
      K_VIC_CLEAN = 3'd2,
      K_RD_VIC    = 3'd3,
      K_RD_PLAIN  = 3'd4
   } kind_e;
endpackage

// File: rtl/wig_ocnt.sv
// Saturating outstanding-command counter with a programmable limit.
module wig_ocnt #(
   parameter int LIM_W    = 3,
   parameter bit ZERO_OFF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LIM_W-1:0] lim,
   input  logic             inc,
   input  logic             dec,
   output logic [LIM_W:0]   cnt,
   output logic             full,
   output logic             undf
);
   localparam int CNT_W = LIM_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             at_lim;
   logic             at_max;
   logic             at_zero;

   if (LIM_W < 1 || LIM_W > 12) begin : g_bad_w
      $error("wig_ocnt: LIM_W out of range");
   end

   // The parameter picks whether a zero limit means "off" or "block all".
   if (ZERO_OFF) begin : g_zero_off
      assign at_lim = (lim != '0) && (cnt_q >= {1'b0, lim});
   end else begin : g_zero_blk
      assign at_lim = (cnt_q >= {1'b0, lim});
   end

   assign at_max  = (cnt_q == '1);
   assign at_zero = (cnt_q == '0);
   assign full    = at_lim || at_max;
   assign undf    = dec && !inc && at_zero;
   assign cnt     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && !dec && !at_max) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc && !at_zero) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/wig_decode.sv
// Per-class grant and count-update decode.
module wig_decode
   import wig_pkg::*;
(
   input  logic       req_vld,
   input  logic [2:0] req_kind,
   input  logic       pair_en,
   input  logic       ack_inh,
   input  logic       vic_full,
   input  logic       ack_full,
   output logic       gnt_vic,
   output logic       gnt_rdvic,
   output logic       gnt_rd,
   output logic       acc,
   output logic       vic_inc,
   output logic       ack_inc
);
   logic ok;
   logic uses_vic;
   logic uses_ack;

   assign gnt_vic   = !vic_full && !ack_full;
   assign gnt_rd    = !ack_full;
   assign gnt_rdvic = !(pair_en && vic_full) && (ack_inh || !ack_full);

   always_comb begin
      ok       = 1'b1;
      uses_vic = 1'b0;
      uses_ack = 1'b0;
      case (req_kind)
         K_VIC_DIRTY, K_VIC_CLEAN: begin
            ok       = gnt_vic;
            uses_vic = 1'b1;
            uses_ack = 1'b1;
         end
         K_RD_VIC: begin
            ok       = gnt_rdvic;
            uses_ack = !ack_inh;
         end
         K_RD_PLAIN: begin
            ok       = gnt_rd;
            uses_ack = 1'b1;
         end
         default: begin
            ok = 1'b1;
         end
      endcase
   end

   assign acc     = req_vld && ok;
   assign vic_inc = acc && uses_vic;
   assign ack_inc = acc && uses_ack;
endmodule

// File: rtl/wig_issue_gate.sv
// Outstanding victim / acknowledge command throttle.
module wig_issue_gate #(
   parameter int VIC_LIM_W     = 3,
   parameter int ACK_LIM_W     = 5,
   parameter bit ZERO_DISABLES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VIC_LIM_W-1:0] cfg_vic_lim,
   input  logic [ACK_LIM_W-1:0] cfg_ack_lim,
   input  logic                 cfg_pair_en,
   input  logic                 cfg_ack_inh,
   input  logic                 req_vld,
   input  logic [2:0]           req_kind,
   input  logic                 vic_done,
   input  logic                 ack_done,
   output logic                 gnt_vic,
   output logic                 gnt_rdvic,
   output logic                 gnt_rd,
   output logic                 req_acc,
   output logic                 vic_stall,
   output logic                 ack_stall,
   output logic [VIC_LIM_W:0]   vic_outstanding,
   output logic [ACK_LIM_W:0]   ack_outstanding,
   output logic                 err_underflow
);
   localparam int VCNT_W = VIC_LIM_W + 1;
   localparam int ACNT_W = ACK_LIM_W + 1;

   logic              vic_inc, ack_inc;
   logic              vic_full, ack_full;
   logic              vic_undf, ack_undf;
   logic              err_q;
   logic [VCNT_W-1:0] vic_cnt;
   logic [ACNT_W-1:0] ack_cnt;

   if (VIC_LIM_W < 1 || ACK_LIM_W < VIC_LIM_W) begin : g_bad_cfg
      $error("wig_issue_gate: acknowledge limit must be at least as wide as victim limit");
   end

   wig_decode u_dec (
      .req_vld   (req_vld),
      .req_kind  (req_kind),
      .pair_en   (cfg_pair_en),
      .ack_inh   (cfg_ack_inh),
      .vic_full  (vic_full),
      .ack_full  (ack_full),
      .gnt_vic   (gnt_vic),
      .gnt_rdvic (gnt_rdvic),
      .gnt_rd    (gnt_rd),
      .acc       (req_acc),
      .vic_inc   (vic_inc),
      .ack_inc   (ack_inc)
   );

   wig_ocnt #(.LIM_W(VIC_LIM_W), .ZERO_OFF(ZERO_DISABLES)) u_vic (
      .clk  (clk),
      .rst_n(rst_n),
      .lim  (cfg_vic_lim),
      .inc  (vic_inc),
      .dec  (vic_done),
      .cnt  (vic_cnt),
      .full (vic_full),
      .undf (vic_undf)
   );

   wig_ocnt #(.LIM_W(ACK_LIM_W), .ZERO_OFF(ZERO_DISABLES)) u_ack (
      .clk  (clk),
      .rst_n(rst_n),
      .lim  (cfg_ack_lim),
      .inc  (ack_inc),
      .dec  (ack_done),
      .cnt  (ack_cnt),
      .full (ack_full),
      .undf (ack_undf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (vic_undf || ack_undf) begin
         err_q <= 1'b1;
      end
   end

   assign vic_stall       = vic_full;
   assign ack_stall       = ack_full;
   assign vic_outstanding = vic_cnt;
   assign ack_outstanding = ack_cnt;
   assign err_underflow   = err_q;
endmodule

// File: rtl/wig_issue_gate_chk.sv
module wig_issue_gate_chk #(
   parameter int VIC_LIM_W     = 3,
   parameter int ACK_LIM_W     = 5,
   parameter bit ZERO_DISABLES = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [VIC_LIM_W-1:0] cfg_vic_lim,
   input logic [ACK_LIM_W-1:0] cfg_ack_lim,
   input logic                 cfg_pair_en,
   input logic                 cfg_ack_inh,
   input logic                 req_vld,
   input logic [2:0]           req_kind,
   input logic                 vic_done,
   input logic                 ack_done,
   input logic                 gnt_vic,
   input logic                 gnt_rdvic,
   input logic                 gnt_rd,
   input logic                 req_acc,
   input logic [VIC_LIM_W:0]   vic_outstanding,
   input logic [ACK_LIM_W:0]   ack_outstanding,
   input logic                 err_underflow
);
   logic vic_on, ack_on, vic_cap, ack_cap, is_vic, no_rsp;

   assign vic_on  = !ZERO_DISABLES || (cfg_vic_lim != '0);
   assign ack_on  = !ZERO_DISABLES || (cfg_ack_lim != '0);
   assign vic_cap = vic_on && (vic_outstanding >= {1'b0, cfg_vic_lim});
   assign ack_cap = ack_on && (ack_outstanding >= {1'b0, cfg_ack_lim});
   assign is_vic  = (req_kind == 3'd1) || (req_kind == 3'd2);
   assign no_rsp  = (req_kind == 3'd0) || (req_kind > 3'd4);

   AST_VIC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      vic_cap |-> !gnt_vic); // R1
   AST_VIC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_DISABLES && cfg_vic_lim == '0 && vic_outstanding == '0 && ack_outstanding == '0) |-> gnt_vic); // R2
   AST_PAIR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pair_en && vic_cap) |-> !gnt_rdvic); // R3
   AST_ACK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      ack_cap |-> (!gnt_rd && !gnt_vic)); // R4
   AST_INH_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_acc && req_kind == 3'd3 && cfg_ack_inh && !ack_done) |=> $stable(ack_outstanding)); // R5
   AST_NORSP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && no_rsp) |-> req_acc); // R6
   AST_NORSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && no_rsp && !vic_done && !ack_done) |=> ($stable(vic_outstanding) && $stable(ack_outstanding))); // R6
   AST_VIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_acc && is_vic && !vic_done) |=> (vic_outstanding == $past(vic_outstanding) + 1'b1)); // R7
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_acc && is_vic && vic_done) |=> $stable(vic_outstanding)); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |=> err_underflow); // R9
   AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_done && vic_outstanding == '0 && !(req_acc && is_vic)) |=> (err_underflow && vic_outstanding == '0)); // R9
endmodule

bind wig_issue_gate wig_issue_gate_chk #(
   .VIC_LIM_W(VIC_LIM_W), .ACK_LIM_W(ACK_LIM_W), .ZERO_DISABLES(ZERO_DISABLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_vic_lim(cfg_vic_lim), .cfg_ack_lim(cfg_ack_lim),
   .cfg_pair_en(cfg_pair_en), .cfg_ack_inh(cfg_ack_inh), .req_vld(req_vld),
   .req_kind(req_kind), .vic_done(vic_done), .ack_done(ack_done),
   .gnt_vic(gnt_vic), .gnt_rdvic(gnt_rdvic), .gnt_rd(gnt_rd), .req_acc(req_acc),
   .vic_outstanding(vic_outstanding), .ack_outstanding(ack_outstanding),
   .err_underflow(err_underflow)
);

// File: tb/sim_wig_issue_gate.sv
module sim_wig_issue_gate;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_vic_lim = 3'd2;
   logic [4:0] cfg_ack_lim = 5'd0;
   logic       cfg_pair_en = 1'b0;
   logic       cfg_ack_inh = 1'b0;
   logic       req_vld = 1'b0;
   logic [2:0] req_kind = 3'd0;
   logic       vic_done = 1'b0;
   logic       ack_done = 1'b0;
   logic       gnt_vic, gnt_rdvic, gnt_rd, req_acc, vic_stall, ack_stall, err_underflow;
   logic [3:0] vic_outstanding;
   logic [5:0] ack_outstanding;

   always #5 clk = ~clk;

   wig_issue_gate u0 (.*);

   typedef struct { int v; int a; int e; string tag; } exp_t;
   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   ev = 0;
   int   ea = 0;
   int   ee = 0;
   bit   done_flag = 1'b0;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int m_vfull();
      return ((cfg_vic_lim != 0 && ev >= cfg_vic_lim) || ev == 15) ? 1 : 0;
   endfunction
   function automatic int m_afull();
      return ((cfg_ack_lim != 0 && ea >= cfg_ack_lim) || ea == 63) ? 1 : 0;
   endfunction

   // Driver: apply one cycle of stimulus, check grants, push expected counts.
   task automatic step(int kind, bit vld, bit vd, bit ad, string tag);
      int gv, gr, grv, acc, vinc, ainc;
      exp_t x;
      @(negedge clk);
      req_vld = vld; req_kind = kind[2:0]; vic_done = vd; ack_done = ad;
      #1;
      gv  = (!m_vfull() && !m_afull()) ? 1 : 0;
      gr  = !m_afull() ? 1 : 0;
      grv = (!(cfg_pair_en && m_vfull()) && (cfg_ack_inh || !m_afull())) ? 1 : 0;
      case (kind)
         1, 2:    acc = vld ? gv : 0;
         3:       acc = vld ? grv : 0;
         4:       acc = vld ? gr : 0;
         default: acc = vld ? 1 : 0;
      endcase
      chk(tag, "gnt_vic", int'(gnt_vic), gv);
      chk(tag, "gnt_rd", int'(gnt_rd), gr);
      chk(tag, "gnt_rdvic", int'(gnt_rdvic), grv);
      chk(tag, "req_acc", int'(req_acc), acc);
      vinc = (acc && (kind == 1 || kind == 2)) ? 1 : 0;
      ainc = (acc && (kind == 1 || kind == 2 || kind == 4 || (kind == 3 && !cfg_ack_inh))) ? 1 : 0;
      if (vinc && !vd) ev++;
      else if (vd && !vinc) begin if (ev == 0) ee = 1; else ev--; end
      if (ainc && !ad) ea++;
      else if (ad && !ainc) begin if (ea == 0) ee = 1; else ea--; end
      x.v = ev; x.a = ea; x.e = ee; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic set_cfg(int vl, int al, bit pe, bit ih);
      exp_t x;
      @(negedge clk);
      req_vld = 0; vic_done = 0; ack_done = 0;
      cfg_vic_lim = vl[2:0]; cfg_ack_lim = al[4:0]; cfg_pair_en = pe; cfg_ack_inh = ih;
      x.v = ev; x.a = ea; x.e = ee; x.tag = "R10";
      q.push_back(x);
   endtask

   // Monitor: compare registered state after each edge.
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t x;
         x = q.pop_front();
         chk(x.tag, "vic_outstanding", int'(vic_outstanding), x.v);
         chk(x.tag, "ack_outstanding", int'(ack_outstanding), x.a);
         chk(x.tag, "err_underflow", int'(err_underflow), x.e);
      end
   end

   initial begin
      #2000000;
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      chk("R11", "vic_outstanding", int'(vic_outstanding), 0);
      chk("R11", "ack_outstanding", int'(ack_outstanding), 0);
      chk("R11", "grants", int'({gnt_vic, gnt_rd, gnt_rdvic}), 7);
      chk("R11", "err_underflow", int'(err_underflow), 0);

      step(1, 1, 0, 0, "R7");    // dirty victim
      step(2, 1, 0, 0, "R7");    // clean victim, reaches limit 2
      step(1, 1, 0, 0, "R1");    // refused
      step(4, 1, 0, 0, "R7");    // plain read, ack only
      step(3, 1, 0, 0, "R3");    // read with victim, unpaired, ack counted (R5)
      set_cfg(2, 0, 1, 0);
      step(3, 1, 0, 0, "R3");    // paired and full: refused
      set_cfg(2, 0, 0, 1);
      step(3, 1, 0, 0, "R5");    // inhibit: no ack count
      step(0, 1, 0, 0, "R6");
      step(5, 1, 0, 0, "R6");
      step(0, 0, 1, 1, "R8");    // plain decrement
      step(2, 1, 1, 1, "R8");    // issue and done in one cycle
      set_cfg(0, 0, 0, 1);
      for (int i = 0; i < 12; i++) step(1 + (i % 2), 1, 0, 0, "R2");
      set_cfg(1, 0, 0, 1);       // lowered below count
      step(0, 0, 0, 0, "R10");
      step(1, 1, 0, 0, "R10");
      set_cfg(0, 4, 0, 1);
      step(4, 1, 0, 0, "R4");
      step(3, 1, 0, 0, "R4");    // inhibit lets it past ack limit
      set_cfg(0, 4, 0, 0);
      step(3, 1, 0, 0, "R4");
      set_cfg(0, 0, 0, 0);
      for (int i = 0; i < 13; i++) step(0, 0, 1, 1, "R8");
      step(0, 0, 0, 1, "R8");
      step(0, 0, 0, 1, "R8");
      step(0, 0, 1, 0, "R9");    // underflow
      step(0, 0, 0, 1, "R9");
      step(1, 1, 1, 0, "R9");    // inc and dec at zero: no change
      step(0, 0, 0, 0, "R9");
      repeat (3) @(negedge clk);
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule